// File: doc/BRIEF.md
# Reset-Time Debug Monitor Entry Controller

After reset is released, this block decides whether the microcontroller starts in a serial debug-monitor mode or in normal user mode. It looks at a high-voltage detect flag on the interrupt pin, two mode-select pins, two communication-select pins, and the two reset-vector bytes read from non-volatile memory. It then drives a monitor flag, a serial-or-parallel communication select, a clock-source select and an entry-method code.

Monitor mode can be reached in two ways. The first is a high-voltage test level on the interrupt pin together with a fixed mode-pin pattern. The second is automatic and applies when both reset-vector bytes read as erased. Either way, communication pin 1 has to be held low for a fixed number of reference-clock cycles after reset. The only case where it may be high is parallel security-code entry, where it is high at the end of that window. The decision is made once, on the last cycle of the window, and then held until the next reset.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: While the synchronous active-low reset is asserted, and until the decision is taken, all outputs are at their user-mode defaults. These defaults are mon_active_o=0, comm_par_o=0, clk_ext_o=0, entry_o=2'b00 and decided_o=0.
- R2: The decision is registered on the WINDOW_CYCLES-th rising clock edge after reset is released. Counting the first released edge as edge 0, this is edge WINDOW_CYCLES-1. decided_o goes to 1 just after that edge and not before.
- R3: The high-voltage method qualifies when irq_hv_i=1, msel1_i=0 and msel0_i=1 at the decision edge.
- R4: The erased-vector method qualifies when vec_hi_i and vec_lo_i both equal ERASED_VAL (0xFF) and irq_hv_i=0 at the decision edge. The mode-select pins are ignored in this case.
- R5: When neither method qualifies, user mode is selected whatever the communication pins do.
- R6: If csel1_i is sampled high on any window edge but is low on the decision edge, monitor entry is aborted and user mode is selected.
- R7: Serial monitor mode (comm_par_o=0) needs csel1_i low on every window edge and csel0_i=1 at the decision edge. If csel1_i stays low but csel0_i=0, user mode is selected.
- R8: If csel1_i is high on the decision edge and a method qualifies, monitor mode is entered with comm_par_o=1. Earlier csel1_i values and csel0_i are ignored in this case.
- R9: clk_ext_o is 1 (external clock) exactly when monitor mode is entered, and 0 (internal oscillator) otherwise.
- R10: entry_o is 2'b01 for the high-voltage method, 2'b10 for the erased-vector method, and 2'b00 in user mode. When both conditions hold, the high-voltage method is reported.
- R11: After the decision, all outputs stay constant until reset is asserted again, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_hv_i | input | 1 | Interrupt pin at high test voltage |
| msel1_i | input | 1 | Mode-select pin 1 |
| msel0_i | input | 1 | Mode-select pin 0 |
| csel1_i | input | 1 | Communication-select pin 1 |
| csel0_i | input | 1 | Communication-select pin 0 |
| vec_hi_i | input | VEC_W | Reset vector high byte |
| vec_lo_i | input | VEC_W | Reset vector low byte |
| mon_active_o | output | 1 | Monitor mode entered |
| comm_par_o | output | 1 | 1 = parallel, 0 = serial communication |
| clk_ext_o | output | 1 | 1 = external clock, 0 = internal oscillator |
| entry_o | output | 2 | Entry method code |
| decided_o | output | 1 | Decision taken |

## Verification
The bench builds the block with its defaults: a 24-cycle window and 8-bit vector bytes with 0xFF as the erased value. These are the real timing values. With them, a high sample on communication pin 1 can be placed on the first edge of the window, on a middle edge, or only on the final edge, and each placement leads to a different outcome. Vector values that differ from 0xFF in a single bit show that the erased check needs both bytes to be fully erased.

// File: rtl/dbg_entry_pkg.sv
// Package: shared types and encodings for the debug monitor entry controller.
// Assumes: the entry-method code is two bits wide and read by software as-is.
package dbg_entry_pkg;

    typedef enum logic [1:0] {
        ENTRY_NONE  = 2'b00,
        ENTRY_HV    = 2'b01,
        ENTRY_BLANK = 2'b10
    } entry_e;

    typedef struct packed {
        logic   mon;
        logic   par;
        logic   ext;
        entry_e ent;
    } decision_t;

    localparam decision_t DECISION_USER = '{mon: 1'b0, par: 1'b0, ext: 1'b0, ent: ENTRY_NONE};

endpackage

// File: rtl/dbg_window_timer.sv
// Module: counts reference-clock edges after reset release and marks the
// sampling window and its final edge.
// Assumes: rst_n is synchronous and active low; the count saturates at the
// window length so it stays put until the next reset.
module dbg_window_timer #(
    parameter int WINDOW_CYCLES = 24
) (
    input  logic clk,
    input  logic rst_n,
    output logic in_window_o,
    output logic last_o
);
    localparam int CW = $clog2(WINDOW_CYCLES + 1);
    localparam logic [CW-1:0] LAST_IDX = CW'(WINDOW_CYCLES - 1);
    localparam logic [CW-1:0] END_IDX  = CW'(WINDOW_CYCLES);

    logic [CW-1:0] count_q;

    // Advance the edge counter until the window has closed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (count_q != END_IDX) begin
            count_q <= count_q + 1'b1;
        end
    end

    // Decode window membership and the decision edge.
    always_comb begin
        in_window_o = (count_q < END_IDX);
        last_o      = (count_q == LAST_IDX);
    end

    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= END_IDX);
    p_last_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !last_o && !in_window_o);

endmodule

// File: rtl/dbg_comm_watch.sv
// Module: watches communication pin 1 over the sampling window and reports
// whether it has been low on every window edge, including the current one.
// Assumes: sample_en is high only during the window.
module dbg_comm_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_en_i,
    input  logic csel1_i,
    output logic held_low_o
);
    logic seen_high_q;

    // Remember any high sample of pin 1 taken inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_high_q <= 1'b0;
        end else if (sample_en_i && csel1_i) begin
            seen_high_q <= 1'b1;
        end
    end

    // Low so far and low right now.
    always_comb begin
        held_low_o = !seen_high_q && !csel1_i;
    end

    p_seen_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        seen_high_q |=> seen_high_q);

endmodule

// File: rtl/dbg_entry_qual.sv
// Module: evaluates the two monitor entry conditions from the pins and the
// reset-vector bytes and picks the entry method, high-voltage first.
// Assumes: inputs are stable around the decision edge.
module dbg_entry_qual
    import dbg_entry_pkg::*;
#(
    parameter int          VEC_W      = 8,
    parameter logic [VEC_W-1:0] ERASED_VAL = '1
) (
    input  logic             irq_hv_i,
    input  logic             msel1_i,
    input  logic             msel0_i,
    input  logic [VEC_W-1:0] vec_hi_i,
    input  logic [VEC_W-1:0] vec_lo_i,
    output entry_e           method_o
);
    logic hv_ok;
    logic blank_ok;

    // Qualify each entry method on its own pin and vector pattern.
    always_comb begin
        hv_ok    = irq_hv_i && !msel1_i && msel0_i;
        blank_ok = !irq_hv_i && (vec_hi_i == ERASED_VAL) && (vec_lo_i == ERASED_VAL);
    end

    // High-voltage entry wins over the erased-vector path.
    always_comb begin
        if (hv_ok) begin
            method_o = ENTRY_HV;
        end else if (blank_ok) begin
            method_o = ENTRY_BLANK;
        end else begin
            method_o = ENTRY_NONE;
        end
    end

    a_method_hv_r10: assert final (!hv_ok || method_o == ENTRY_HV);

endmodule

// File: rtl/dbg_entry_ctrl.sv
// Module: top of the reset-time debug monitor entry controller. Samples the
// pins over a fixed window after reset and registers a one-time decision.
// Assumes: synchronous active-low reset; outputs hold until the next reset.
module dbg_entry_ctrl
    import dbg_entry_pkg::*;
#(
    parameter int               WINDOW_CYCLES = 24,
    parameter int               VEC_W         = 8,
    parameter logic [VEC_W-1:0] ERASED_VAL    = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_hv_i,
    input  logic             msel1_i,
    input  logic             msel0_i,
    input  logic             csel1_i,
    input  logic             csel0_i,
    input  logic [VEC_W-1:0] vec_hi_i,
    input  logic [VEC_W-1:0] vec_lo_i,
    output logic             mon_active_o,
    output logic             comm_par_o,
    output logic             clk_ext_o,
    output logic [1:0]       entry_o,
    output logic             decided_o
);
    logic      in_window;
    logic      last_edge;
    logic      held_low;
    entry_e    method;
    decision_t next_dec;
    decision_t dec_q;
    logic      decided_q;

    dbg_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_window_o (in_window),
        .last_o      (last_edge)
    );

    dbg_comm_watch u_watch (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_en_i (in_window),
        .csel1_i     (csel1_i),
        .held_low_o  (held_low)
    );

    dbg_entry_qual #(.VEC_W(VEC_W), .ERASED_VAL(ERASED_VAL)) u_qual (
        .irq_hv_i (irq_hv_i),
        .msel1_i  (msel1_i),
        .msel0_i  (msel0_i),
        .vec_hi_i (vec_hi_i),
        .vec_lo_i (vec_lo_i),
        .method_o (method)
    );

    // Form the candidate decision from method and communication pins.
    always_comb begin
        next_dec = DECISION_USER;
        if (method != ENTRY_NONE) begin
            if (csel1_i) begin
                next_dec = '{mon: 1'b1, par: 1'b1, ext: 1'b1, ent: method};
            end else if (held_low && csel0_i) begin
                next_dec = '{mon: 1'b1, par: 1'b0, ext: 1'b1, ent: method};
            end
        end
    end

    // Latch the decision once, on the final window edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q     <= DECISION_USER;
            decided_q <= 1'b0;
        end else if (last_edge && !decided_q) begin
            dec_q     <= next_dec;
            decided_q <= 1'b1;
        end
    end

    // Drive the ports from the held decision.
    always_comb begin
        mon_active_o = dec_q.mon;
        comm_par_o   = dec_q.par;
        clk_ext_o    = dec_q.ext;
        entry_o      = dec_q.ent;
        decided_o    = decided_q;
    end

    p_defaults_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !decided_o |-> !mon_active_o && !comm_par_o && !clk_ext_o && entry_o == 2'b00);
    p_decide_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(decided_o) |-> $past(last_edge));
    p_clk_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clk_ext_o == mon_active_o);
    p_par_needs_mon_r8: assert property (@(posedge clk) disable iff (!rst_n)
        comm_par_o |-> mon_active_o);
    p_entry_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mon_active_o == (entry_o != 2'b00));
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        decided_o |=> $stable(mon_active_o) && $stable(comm_par_o) && $stable(entry_o) && decided_o);

endmodule

// File: tb/dbg_entry_ctrl_test.sv
module dbg_entry_ctrl_test;
    localparam int W = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_hv = 1'b0, m1 = 1'b0, m0 = 1'b0, c1 = 1'b0, c0 = 1'b0;
    logic [7:0] vh = 8'h00, vl = 8'h00;
    logic       mon, par, ext, dec;
    logic [1:0] ent;

    int total = 0;
    int bad = 0;

    // reference model state
    int   k_m;
    bit   seen_m, dec_m, mon_m, par_m, ext_m;
    int   ent_m;

    always #5 clk = ~clk;

    dbg_entry_ctrl uut (
        .clk(clk), .rst_n(rst_n), .irq_hv_i(irq_hv), .msel1_i(m1), .msel0_i(m0),
        .csel1_i(c1), .csel0_i(c0), .vec_hi_i(vh), .vec_lo_i(vl),
        .mon_active_o(mon), .comm_par_o(par), .clk_ext_o(ext), .entry_o(ent), .decided_o(dec)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural model of one rising edge
    task automatic model_edge();
        bit hv, blank, final_low;
        int e;
        if (!rst_n) begin
            k_m = 0; seen_m = 0; dec_m = 0; mon_m = 0; par_m = 0; ext_m = 0; ent_m = 0;
        end else begin
            if (!dec_m && k_m == W - 1) begin
                hv = irq_hv && !m1 && m0;
                blank = !irq_hv && vh == 8'hFF && vl == 8'hFF;
                e = hv ? 1 : (blank ? 2 : 0);
                final_low = !seen_m && !c1;
                dec_m = 1;
                if (e != 0 && c1) begin
                    mon_m = 1; par_m = 1; ext_m = 1; ent_m = e;
                end else if (e != 0 && final_low && c0) begin
                    mon_m = 1; par_m = 0; ext_m = 1; ent_m = e;
                end
            end
            if (k_m < W && c1) seen_m = 1;
            if (k_m < W) k_m++;
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R2 model dec", dec, int'(dec_m));
        chk("R11 model mon", mon, int'(mon_m));
        chk("R8 model par", par, int'(par_m));
        chk("R9 model ext", ext, int'(ext_m));
        chk("R10 model ent", ent, ent_m);
    endtask

    task automatic run_case(input string req, input bit i_hv, input bit i_m1, input bit i_m0,
                            input logic [7:0] i_vh, input logic [7:0] i_vl, input bit i_c0,
                            input int abort_at, input bit final_high,
                            input bit e_mon, input bit e_par, input int e_ent);
        rst_n = 0; c1 = 0;
        irq_hv = i_hv; m1 = i_m1; m0 = i_m0; vh = i_vh; vl = i_vl; c0 = i_c0;
        for (int i = 0; i < 3; i++) step();
        chk({req, " R1 reset mon"}, mon, 0);
        chk({req, " R1 reset dec"}, dec, 0);
        rst_n = 1;
        for (int i = 0; i < W; i++) begin
            c1 = (i == abort_at) || (final_high && i == W - 1);
            if (i == W - 1) chk({req, " R2 not yet decided"}, dec, 0);
            step();
        end
        c1 = 0;
        chk({req, " R2 decided"}, dec, 1);
        chk({req, " mon"}, mon, e_mon);
        chk({req, " par"}, par, e_par);
        chk({req, " R9 ext"}, ext, e_mon);
        chk({req, " R10 ent"}, ent, e_ent);
        // disturb every input after the decision
        irq_hv = ~i_hv; m1 = ~i_m1; m0 = ~i_m0; vh = ~i_vh; vl = ~i_vl; c0 = ~i_c0; c1 = 1;
        for (int i = 0; i < 4; i++) step();
        chk({req, " R11 hold mon"}, mon, e_mon);
        chk({req, " R11 hold ent"}, ent, e_ent);
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        run_case("R3 hv serial",       1, 0, 1, 8'h12, 8'h34, 1, -1, 0, 1, 0, 1);
        run_case("R3 hv bad mode",     1, 0, 0, 8'h12, 8'h34, 1, -1, 0, 0, 0, 0);
        run_case("R3 hv bad mode1",    1, 1, 1, 8'h12, 8'h34, 1, -1, 0, 0, 0, 0);
        run_case("R4 blank serial",    0, 1, 0, 8'hFF, 8'hFF, 1, -1, 0, 1, 0, 2);
        run_case("R5 lo not erased",   0, 0, 1, 8'hFF, 8'hFE, 1, -1, 0, 0, 0, 0);
        run_case("R5 hi not erased",   0, 0, 1, 8'h7F, 8'hFF, 1, -1, 0, 0, 0, 0);
        run_case("R10 both hv wins",   1, 0, 1, 8'hFF, 8'hFF, 1, -1, 0, 1, 0, 1);
        run_case("R10 hv level no blank", 1, 1, 0, 8'hFF, 8'hFF, 1, -1, 0, 0, 0, 0);
        run_case("R6 abort first",     1, 0, 1, 8'h00, 8'h00, 1, 0, 0, 0, 0, 0);
        run_case("R6 abort middle",    0, 0, 0, 8'hFF, 8'hFF, 1, 12, 0, 0, 0, 0);
        run_case("R7 serial c0 low",   1, 0, 1, 8'h00, 8'h00, 0, -1, 0, 0, 0, 0);
        run_case("R8 parallel",        1, 0, 1, 8'h00, 8'h00, 0, -1, 1, 1, 1, 1);
        run_case("R8 parallel blank",  0, 1, 1, 8'hFF, 8'hFF, 1, 5, 1, 1, 1, 2);
        run_case("R5 parallel no method", 0, 0, 1, 8'h00, 8'hFF, 1, -1, 1, 0, 0, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule